// File: doc/BRIEF.md
# Condition and Status Field Update Unit

This unit keeps two 32-bit registers side by side: a condition register and a floating-point status/control register. Each is split into eight 4-bit fields. Field 0 is the most significant nibble and field 7 is the least significant. An execution pipeline drives one operation per cycle on an op-code input, together with the operand fields that the operation needs. The updated registers appear on the outputs on the following cycle, and the condition register can always be read in full from its output.

The unit supports the following operations:
- Copy one condition field into another.
- Overwrite selected condition fields from a data word, under an 8-bit field mask.
- Do the same masked overwrite on the status register.
- Load a 4-bit immediate into one status field.
- Set or clear a single status bit.

Two status bits are protected: a single-bit write that targets them changes nothing. Flag updates for record forms are not part of this unit, and neither is exception generation.

Top module: `flagfield_unit`

## Requirements
- R1: While reset is low, and on the first rising edge after reset is released with op 0, both `cr_q` and `sr_q` read zero.
- R2: Op-code values are: 0 idle, 1 condition field copy, 2 condition masked write, 3 status masked write, 4 status field immediate, 5 status bit set, 6 status bit clear. Codes 0 and 7 leave both registers unchanged. The effect of an op presented before a rising edge is visible on the outputs after that edge.
- R3: Field f (0 to 7) occupies bits [31-4f : 28-4f]. Field 0 is bits [31:28], and field 7 is bits [3:0].
- R4: A field copy (op 1) places the nibble of field `fld_src` into field `fld_dst` of the condition register. It leaves the other seven nibbles unchanged, and this includes the case where source and destination are the same field.
- R5: Each set bit k of `fmask` selects a full 4-bit nibble. `fmask[7]` selects field 0 (the top nibble), and `fmask[0]` selects field 7.
- R6: A condition masked write (op 2) gives `(wdata & M) | (cr & ~M)`, where M is the expanded nibble mask. A mask of zero leaves the register unchanged.
- R7: A status masked write (op 3) gives `(wdata & M) | (sr & ~M)`.
- R8: A status field immediate (op 4) sets field `fld_dst` of the status register to `imm`, whatever the old contents of that nibble. Other nibbles are preserved.
- R9: A bit set (op 5) or bit clear (op 6) writes 1 or 0 to status bit `31 - bit_idx` and leaves all other bits unchanged.
- R10: A bit set or bit clear with `bit_idx` equal to 1 or 2 leaves the status register unchanged.
- R11: Ops 1 and 2 never change the status register. Ops 3 to 6 never change the condition register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op | input | 3 | Operation code, sampled every cycle |
| fld_dst | input | 3 | Destination field index |
| fld_src | input | 3 | Source field index for a copy |
| fmask | input | 8 | Field mask for the masked writes |
| wdata | input | 32 | Data word for the masked writes |
| imm | input | 4 | Immediate nibble for a status field load |
| bit_idx | input | 5 | Bit index for a single-bit set or clear |
| cr_q | output | 32 | Condition register contents |
| sr_q | output | 32 | Status/control register contents |

## Verification
The checker assumes that every operand input holds a known value on each clock edge where reset is high, including operands that the current op does not use. The properties sample past operand values for each op and compare them with the register nibbles, so an unknown operand would make those comparisons meaningless. The bench therefore holds every input at a defined value from time zero, keeps op at idle through reset, and changes inputs only on falling edges. Field and bit indices are driven across their full ranges, including the two protected indices and copies of a field onto itself.

// File: rtl/flagfield_unit.sv
module flagfield_unit #(
  parameter int NF = 8,
  parameter int FW = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [2:0]              op,
  input  logic [$clog2(NF)-1:0]   fld_dst,
  input  logic [$clog2(NF)-1:0]   fld_src,
  input  logic [NF-1:0]           fmask,
  input  logic [NF*FW-1:0]        wdata,
  input  logic [FW-1:0]           imm,
  input  logic [$clog2(NF*FW)-1:0] bit_idx,
  output logic [NF*FW-1:0]        cr_q,
  output logic [NF*FW-1:0]        sr_q
);
  localparam int W  = NF * FW;
  localparam int IW = $clog2(NF);
  localparam int BW = $clog2(W);

  localparam logic [2:0] OP_CPY  = 3'd1;
  localparam logic [2:0] OP_CRMW = 3'd2;
  localparam logic [2:0] OP_SRMW = 3'd3;
  localparam logic [2:0] OP_SRIM = 3'd4;
  localparam logic [2:0] OP_BSET = 3'd5;
  localparam logic [2:0] OP_BCLR = 3'd6;

  logic [W-1:0]  nmask, dst_m, bit_m, cpy_val, mw_cr, mw_sr, im_sr;
  logic [BW-1:0] src_sh, dst_sh, bpos;
  logic [FW-1:0] src_nib;
  logic          bit_lock;

  genvar k;
  generate
    for (k = 0; k < NF; k++) begin : g_nib
      assign nmask[W-1-FW*k -: FW] = {FW{fmask[NF-1-k]}};
    end
  endgenerate

  assign src_sh  = BW'(FW) * BW'(IW'(NF-1) - fld_src);
  assign dst_sh  = BW'(FW) * BW'(IW'(NF-1) - fld_dst);
  assign src_nib = FW'(cr_q >> src_sh);
  assign dst_m   = W'({FW{1'b1}}) << dst_sh;

  assign cpy_val = (cr_q & ~dst_m) | (W'(src_nib) << dst_sh);
  assign mw_cr   = (wdata & nmask) | (cr_q & ~nmask);
  assign mw_sr   = (wdata & nmask) | (sr_q & ~nmask);
  assign im_sr   = (sr_q & ~dst_m) | (W'(imm) << dst_sh);

  assign bpos     = BW'(W-1) - bit_idx;
  assign bit_m    = W'(1) << bpos;
  assign bit_lock = (bit_idx == BW'(1)) || (bit_idx == BW'(2));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cr_q <= '0;
      sr_q <= '0;
    end else begin
      case (op)
        OP_CPY:  cr_q <= cpy_val;
        OP_CRMW: cr_q <= mw_cr;
        OP_SRMW: sr_q <= mw_sr;
        OP_SRIM: sr_q <= im_sr;
        OP_BSET: if (!bit_lock) sr_q <= sr_q | bit_m;
        OP_BCLR: if (!bit_lock) sr_q <= sr_q & ~bit_m;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/flagfield_unit_chk.sv
module flagfield_unit_chk #(
  parameter int NF = 8,
  parameter int FW = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [2:0]               op,
  input logic [$clog2(NF)-1:0]    fld_dst,
  input logic [$clog2(NF)-1:0]    fld_src,
  input logic [NF-1:0]            fmask,
  input logic [NF*FW-1:0]         wdata,
  input logic [FW-1:0]            imm,
  input logic [$clog2(NF*FW)-1:0] bit_idx,
  input logic [NF*FW-1:0]         cr_q,
  input logic [NF*FW-1:0]         sr_q
);
  localparam int W  = NF * FW;
  localparam int IW = $clog2(NF);
  localparam int BW = $clog2(W);

  function automatic logic [FW-1:0] nib(input logic [W-1:0] v, input logic [IW-1:0] f);
    return v[W-1-FW*int'(f) -: FW];
  endfunction

  function automatic logic bit_of(input logic [W-1:0] v, input logic [BW-1:0] i);
    return v[W-1-int'(i)];
  endfunction

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      #1;
      reset_zero_chk: assert (cr_q == '0 && sr_q == '0);
    end
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd0 || op == 3'd7) |=> ($stable(cr_q) && $stable(sr_q)));

  // R4
  copy_nib_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd1) |=> nib(cr_q, $past(fld_dst)) == nib($past(cr_q), $past(fld_src)));

  // R8
  imm_nib_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd4) |=> nib(sr_q, $past(fld_dst)) == $past(imm));

  // R9
  bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd5 && bit_idx != 5'd1 && bit_idx != 5'd2) |=> bit_of(sr_q, $past(bit_idx)));

  // R9
  bit_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd6 && bit_idx != 5'd1 && bit_idx != 5'd2) |=> !bit_of(sr_q, $past(bit_idx)));

  // R10
  locked_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == 3'd5 || op == 3'd6) && (bit_idx == 5'd1 || bit_idx == 5'd2)) |=> $stable(sr_q));

  // R6
  zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd2 && fmask == '0) |=> $stable(cr_q));

  // R11
  cr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd1 || op == 3'd2) |=> $stable(sr_q));

  // R11
  sr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op >= 3'd3 && op <= 3'd6) |=> $stable(cr_q));
endmodule

bind flagfield_unit flagfield_unit_chk #(.NF(NF), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .fld_dst(fld_dst), .fld_src(fld_src),
  .fmask(fmask), .wdata(wdata), .imm(imm), .bit_idx(bit_idx),
  .cr_q(cr_q), .sr_q(sr_q)
);

// File: tb/sim_flagfield_unit.sv
module sim_flagfield_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [2:0]  fld_dst = 3'd0, fld_src = 3'd0;
  logic [7:0]  fmask = 8'd0;
  logic [31:0] wdata = 32'd0;
  logic [3:0]  imm = 4'd0;
  logic [4:0]  bit_idx = 5'd0;
  logic [31:0] cr_q, sr_q;

  int checks = 0, errors = 0;
  logic [31:0] e_cr = 0, e_sr = 0;
  logic [31:0] q_cr[$], q_sr[$];
  string       q_tag[$];
  bit          done = 0;

  always #2 clk = ~clk;

  flagfield_unit u0 (.clk(clk), .rst_n(rst_n), .op(op), .fld_dst(fld_dst),
    .fld_src(fld_src), .fmask(fmask), .wdata(wdata), .imm(imm),
    .bit_idx(bit_idx), .cr_q(cr_q), .sr_q(sr_q));

  function automatic logic [31:0] expand(input logic [7:0] m);
    logic [31:0] r = 0;
    for (int f = 0; f < 8; f++)
      if (m[7-f]) for (int b = 0; b < 4; b++) r[31-4*f-b] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] put_nib(input logic [31:0] v, input int f, input logic [3:0] n);
    for (int b = 0; b < 4; b++) v[28-4*f+b] = n[b];
    return v;
  endfunction

  function automatic logic [3:0] get_nib(input logic [31:0] v, input int f);
    logic [3:0] n;
    for (int b = 0; b < 4; b++) n[b] = v[28-4*f+b];
    return n;
  endfunction

  task automatic do_op(input logic [2:0] o, input int d, input int s, input logic [7:0] m,
                       input logic [31:0] wd, input logic [3:0] im, input int idx, input string tag);
    @(negedge clk);
    op = o; fld_dst = 3'(d); fld_src = 3'(s); fmask = m; wdata = wd; imm = im; bit_idx = 5'(idx);
    case (o)
      3'd1: e_cr = put_nib(e_cr, d, get_nib(e_cr, s));
      3'd2: e_cr = (wd & expand(m)) | (e_cr & ~expand(m));
      3'd3: e_sr = (wd & expand(m)) | (e_sr & ~expand(m));
      3'd4: e_sr = put_nib(e_sr, d, im);
      3'd5: if (idx != 1 && idx != 2) e_sr[31-idx] = 1'b1;
      3'd6: if (idx != 1 && idx != 2) e_sr[31-idx] = 1'b0;
      default: ;
    endcase
    q_cr.push_back(e_cr); q_sr.push_back(e_sr); q_tag.push_back(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (q_tag.size() > 0) begin
      logic [31:0] xc, xs;
      string t;
      xc = q_cr.pop_front(); xs = q_sr.pop_front(); t = q_tag.pop_front();
      checks++;
      if (cr_q !== xc || sr_q !== xs) begin
        errors++;
        $display("FAIL %s: cr=%h sr=%h expected cr=%h sr=%h", t, cr_q, sr_q, xc, xs);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (cr_q !== 0 || sr_q !== 0) begin
      errors++;
      $display("FAIL R1: cr=%h sr=%h expected cr=0 sr=0", cr_q, sr_q);
    end
    rst_n = 1'b1;
    do_op(3'd0, 0, 0, 8'h00, 32'h0, 4'h0, 0, "R1");
    // R5 R6 mask expansion and masked write of the condition register
    do_op(3'd2, 0, 0, 8'h81, 32'hDEADBEEF, 4'h0, 0, "R5");
    do_op(3'd2, 0, 0, 8'hFF, 32'h12345678, 4'h0, 0, "R6");
    do_op(3'd2, 0, 0, 8'h00, 32'hFFFFFFFF, 4'h0, 0, "R6");
    do_op(3'd2, 0, 0, 8'h24, 32'hAAAAAAAA, 4'h0, 0, "R5");
    // R3 R4 field copy
    do_op(3'd1, 7, 0, 8'h00, 32'h0, 4'h0, 0, "R4");
    do_op(3'd1, 0, 5, 8'h00, 32'h0, 4'h0, 0, "R3");
    do_op(3'd1, 3, 3, 8'h00, 32'h0, 4'h0, 0, "R4");
    // R2 idle codes
    do_op(3'd0, 2, 6, 8'hFF, 32'hFFFFFFFF, 4'hF, 0, "R2");
    do_op(3'd7, 2, 6, 8'hFF, 32'hFFFFFFFF, 4'hF, 5, "R2");
    // R7 status masked write
    do_op(3'd3, 0, 0, 8'hF0, 32'hCAFEF00D, 4'h0, 0, "R7");
    do_op(3'd3, 0, 0, 8'h0F, 32'h0BADC0DE, 4'h0, 0, "R7");
    // R8 immediate field
    do_op(3'd4, 0, 0, 8'h00, 32'h0, 4'h9, 0, "R8");
    do_op(3'd4, 7, 0, 8'h00, 32'h0, 4'h0, 0, "R8");
    do_op(3'd4, 3, 0, 8'h00, 32'h0, 4'h5, 0, "R3");
    // R9 bit set/clear
    do_op(3'd5, 0, 0, 8'h00, 32'h0, 4'h0, 31, "R9");
    do_op(3'd6, 0, 0, 8'h00, 32'h0, 4'h0, 0, "R9");
    do_op(3'd5, 0, 0, 8'h00, 32'h0, 4'h0, 0, "R9");
    do_op(3'd6, 0, 0, 8'h00, 32'h0, 4'h0, 4, "R9");
    // R10 protected bits
    do_op(3'd3, 0, 0, 8'hFF, 32'h00000000, 4'h0, 0, "R7");
    do_op(3'd5, 0, 0, 8'h00, 32'h0, 4'h0, 1, "R10");
    do_op(3'd5, 0, 0, 8'h00, 32'h0, 4'h0, 2, "R10");
    do_op(3'd3, 0, 0, 8'hFF, 32'hFFFFFFFF, 4'h0, 0, "R7");
    do_op(3'd6, 0, 0, 8'h00, 32'h0, 4'h0, 1, "R10");
    do_op(3'd6, 0, 0, 8'h00, 32'h0, 4'h0, 2, "R10");
    // R11 mixed traffic
    for (int i = 0; i < 300; i++)
      do_op(3'($urandom_range(0, 7)), $urandom_range(0, 7), $urandom_range(0, 7),
            8'($urandom), $urandom, 4'($urandom), $urandom_range(0, 31), "R11");
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule